// File: doc/BRIEF.md
# Banked Extended RAM Window

This block puts a large byte-wide RAM behind a small indirect register window on a simple byte-register bus. Software first sets the bank-select bit in the primary control register, which opens a second bank of registers. In that bank, two address registers (low and high byte) together form the RAM address. A data-port register then reads or writes the RAM byte at that address.

An extended control register holds a burst-enable bit. When burst mode is built in and the bit is set, every data-port read or write moves the RAM address to the next location, so that a block of bytes streams through the one port. The address wraps from the last location back to zero. When burst mode is not built in, the same bit can still be written and read back but does nothing. The RAM size is a power-of-two parameter (128, 2048, 4096 or 8192 bytes in typical use). Address bits above that size are not stored.

Top module: `xram_window`

## Requirements
- R1: After reset the primary control register reads 0x00, the burst-enable bit reads 0 and both address registers read 0x00.
- R2: The primary control register at offset 0x0A is a full 8-bit read/write register, and its bit 4 is the bank-select bit.
- R3: While bank-select is 0, offsets 0x4A, 0x50, 0x51 and 0x53 read 0x00, writes to them change nothing, and data-port accesses do not move the address.
- R4: With bank-select at 1, offset 0x50 holds address bits 7:0 and offset 0x51 holds address bits 15:8, and both read back what was stored.
- R5: Address bits at and above log2(RAM_BYTES) are dropped on write and read back as 0.
- R6: A write to the data port at offset 0x53 stores the byte at the current address, and a read of 0x53 returns the byte at the current address in the same cycle.
- R7: With BURST_EN=1 and bit 5 of offset 0x4A set, the address increments by one after every data-port read or write.
- R8: An increment from address RAM_BYTES-1 gives address 0.
- R9: With bit 5 of offset 0x4A clear, data-port accesses leave the address unchanged.
- R10: With BURST_EN=0, bit 5 of offset 0x4A is still read/write, but data-port accesses never change the address.
- R11: Bits of offset 0x4A other than bit 5 read 0, and unmapped offsets read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (triggers burst stepping on the data port) |
| bus_addr | input | 7 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |

## Verification
The assertions assume that the bus never raises the read and write strobes in the same cycle. The address-stepping checks count each such cycle as a single port access. The bench drives one operation per cycle, always on the falling edge, with exactly one strobe high. It samples read data before the next rising edge, so each read sees the address from before the step that the read itself causes. A second instance built without burst support gets its own strobes, so that it never receives the stimulus meant for the first instance.

// File: rtl/xram_window.sv
module xram_window #(
  parameter int RAM_BYTES = 128,
  parameter bit BURST_EN  = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [6:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);
  localparam int AW = $clog2(RAM_BYTES);
  localparam logic [6:0] OFS_CTL  = 7'h0A;
  localparam logic [6:0] OFS_EXT  = 7'h4A;
  localparam logic [6:0] OFS_ALO  = 7'h50;
  localparam logic [6:0] OFS_AHI  = 7'h51;
  localparam logic [6:0] OFS_PORT = 7'h53;

  logic [7:0]    ctl_reg;
  logic          burst_bit;
  logic [AW-1:0] ram_addr;
  logic [7:0]    mem [RAM_BYTES];

  wire        bank     = ctl_reg[4];
  wire [15:0] addr_w   = 16'(ram_addr);
  wire        port_hit = bank && (bus_addr == OFS_PORT);
  wire        step     = port_hit && (bus_wr || bus_rd) && burst_bit && BURST_EN;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_reg   <= 8'h00;
      burst_bit <= 1'b0;
      ram_addr  <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          OFS_CTL: ctl_reg <= bus_wdata;
          OFS_EXT: if (bank) burst_bit <= bus_wdata[5];
          OFS_ALO: if (bank) ram_addr <= AW'({addr_w[15:8], bus_wdata});
          OFS_AHI: if (bank) ram_addr <= AW'({bus_wdata, addr_w[7:0]});
          default: ;
        endcase
      end
      if (step) ram_addr <= ram_addr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (bus_wr && port_hit) mem[ram_addr] <= bus_wdata;
  end

  always_comb begin
    case (bus_addr)
      OFS_CTL:  bus_rdata = ctl_reg;
      OFS_EXT:  bus_rdata = bank ? {2'b00, burst_bit, 5'b00000} : 8'h00;
      OFS_ALO:  bus_rdata = bank ? addr_w[7:0] : 8'h00;
      OFS_AHI:  bus_rdata = bank ? addr_w[15:8] : 8'h00;
      OFS_PORT: bus_rdata = bank ? mem[ram_addr] : 8'h00;
      default:  bus_rdata = 8'h00;
    endcase
  end
endmodule

module xram_window_chk #(
  parameter int AW       = 7,
  parameter bit BURST_EN = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [6:0]    bus_addr,
  input logic [7:0]    bus_rdata,
  input logic          bank,
  input logic          burst_bit,
  input logic [AW-1:0] ram_addr
);
  localparam int HB = (AW > 8) ? AW - 8 : 0;
  wire in_win   = (bus_addr == 7'h4A) || (bus_addr == 7'h50) ||
                  (bus_addr == 7'h51) || (bus_addr == 7'h53);
  wire port_acc = bank && (bus_addr == 7'h53) && (bus_wr || bus_rd);

  // R3
  bank_off_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank && in_win) |-> (bus_rdata == 8'h00));
  // R3
  bank_off_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank && (bus_wr || bus_rd)) |=> $stable(ram_addr));
  // R9
  no_burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_acc && !(burst_bit && BURST_EN)) |=> $stable(ram_addr));
  // R7
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_acc && burst_bit && BURST_EN) |=> (ram_addr == $past(ram_addr) + 1'b1));
  // R5
  hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank && bus_addr == 7'h51) |-> ((16'(bus_rdata) >> HB) == 16'h0000));
  // R11
  ext_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 7'h4A) |-> ((bus_rdata & 8'hDF) == 8'h00));
endmodule

bind xram_window xram_window_chk #(.AW(AW), .BURST_EN(BURST_EN)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bank(bank),
  .burst_bit(burst_bit), .ram_addr(ram_addr)
);

// File: tb/xram_window_tb_top.sv
module xram_window_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_a = 1'b0, rd_a = 1'b0, wr_b = 1'b0, rd_b = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata_a, rdata_b;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xram_window #(.RAM_BYTES(2048), .BURST_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_a), .bus_rd(rd_a),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_a));

  xram_window #(.RAM_BYTES(128), .BURST_EN(1'b0)) dut_nb_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_b), .bus_rd(rd_b),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_b));

  // {is_read, offset, data/expected, requirement}
  localparam int NV = 42;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 7'h0A, 8'h10, 4'd2},  {1'b1, 7'h0A, 8'h10, 4'd2},   // R2 bank on
    {1'b0, 7'h4A, 8'hFF, 4'd11}, {1'b1, 7'h4A, 8'h20, 4'd11},  // R11 spare bits
    {1'b0, 7'h50, 8'hFE, 4'd4},  {1'b0, 7'h51, 8'h07, 4'd4},   // R4
    {1'b1, 7'h50, 8'hFE, 4'd4},  {1'b1, 7'h51, 8'h07, 4'd4},
    {1'b0, 7'h53, 8'hA1, 4'd6},  {1'b0, 7'h53, 8'hB2, 4'd7},   // R6 R7 burst writes
    {1'b0, 7'h53, 8'hC3, 4'd7},
    {1'b1, 7'h50, 8'h01, 4'd8},  {1'b1, 7'h51, 8'h00, 4'd8},   // R8 wrapped
    {1'b0, 7'h50, 8'hFE, 4'd4},  {1'b0, 7'h51, 8'h07, 4'd4},
    {1'b1, 7'h53, 8'hA1, 4'd6},  {1'b1, 7'h53, 8'hB2, 4'd8},   // R7 burst reads
    {1'b1, 7'h53, 8'hC3, 4'd7},  {1'b1, 7'h50, 8'h01, 4'd7},
    {1'b0, 7'h4A, 8'h00, 4'd9},  {1'b1, 7'h4A, 8'h00, 4'd9},   // R9 burst off
    {1'b0, 7'h50, 8'h10, 4'd9},  {1'b0, 7'h51, 8'h00, 4'd9},
    {1'b0, 7'h53, 8'h5A, 4'd9},  {1'b1, 7'h50, 8'h10, 4'd9},
    {1'b1, 7'h53, 8'h5A, 4'd9},  {1'b1, 7'h53, 8'h5A, 4'd9},
    {1'b1, 7'h50, 8'h10, 4'd9},
    {1'b0, 7'h51, 8'hFF, 4'd5},  {1'b1, 7'h51, 8'h07, 4'd5},   // R5 masking
    {1'b0, 7'h51, 8'h00, 4'd5},
    {1'b0, 7'h0A, 8'h0F, 4'd3},  {1'b1, 7'h0A, 8'h0F, 4'd2},   // R3 bank off
    {1'b1, 7'h50, 8'h00, 4'd3},  {1'b1, 7'h53, 8'h00, 4'd3},
    {1'b0, 7'h50, 8'h33, 4'd3},  {1'b0, 7'h4A, 8'h20, 4'd3},
    {1'b1, 7'h53, 8'h00, 4'd3},
    {1'b0, 7'h0A, 8'h10, 4'd3},  {1'b1, 7'h50, 8'h10, 4'd3},
    {1'b1, 7'h4A, 8'h00, 4'd3},  {1'b1, 7'h20, 8'h00, 4'd11}   // R11 unmapped
  };

  task automatic op(input bit tgt_b, input bit is_rd, input logic [6:0] a,
                    input logic [7:0] d, input int req);
    logic [7:0] got;
    @(negedge clk);
    addr = a; wdata = d;
    wr_a = !is_rd && !tgt_b; rd_a = is_rd && !tgt_b;
    wr_b = !is_rd && tgt_b;  rd_b = is_rd && tgt_b;
    #1;
    if (is_rd) begin
      got = tgt_b ? rdata_b : rdata_a;
      tests++;
      if (got !== d) begin
        fails++;
        $display("FAIL R%0d offset %h: got %h expected %h", req, a, got, d);
      end
    end
    @(posedge clk); #1;
    wr_a = 0; rd_a = 0; wr_b = 0; rd_b = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    op(0, 1, 7'h0A, 8'h00, 1);
    op(0, 0, 7'h0A, 8'h10, 1);
    op(0, 1, 7'h4A, 8'h00, 1);
    op(0, 1, 7'h50, 8'h00, 1);
    op(0, 1, 7'h51, 8'h00, 1);
    for (int i = 0; i < NV; i++)
      op(0, VEC[i][19], VEC[i][18:12], VEC[i][11:4], int'(VEC[i][3:0]));
    // R10 burst bit stored but inert without burst support
    op(1, 0, 7'h0A, 8'h10, 10);
    op(1, 0, 7'h4A, 8'h20, 10);
    op(1, 1, 7'h4A, 8'h20, 10);
    op(1, 0, 7'h50, 8'h05, 10);
    op(1, 0, 7'h53, 8'h77, 10);
    op(1, 1, 7'h50, 8'h05, 10);
    op(1, 1, 7'h53, 8'h77, 10);
    op(1, 1, 7'h50, 8'h05, 10);
    // R5 on a 128-byte RAM: bit 7 of the low register is dropped
    op(1, 0, 7'h50, 8'hFF, 5);
    op(1, 1, 7'h50, 8'h7F, 5);
    op(1, 1, 7'h51, 8'h00, 5);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule